// File: doc/BRIEF.md
# Compact Test Response Analyzer

This block watches one sampled test-point bit and reduces the whole response seen during a measurement window to a single 16-bit fault signature. It then compares that signature with a fault-free reference value. Three compression methods are available, chosen when the window opens. Transition counting counts every change of the bit. Ones counting counts every sampled 1. Signature mode shifts the bit through a 16-bit linear feedback shift register. The result is also split into four hexadecimal digits so that an operator can read it from a display.

A tester holds `win_en` high for the length of the measurement and drives one response bit per clock on `din`. The analyzer is controlled by a three-state machine. `IDLE` waits for a window. `ACQ` takes one sample per cycle. `REPORT` lasts exactly one cycle after the window closes and raises `done`.

The machine has five transitions:
- OPEN: `IDLE` to `ACQ` when `win_en` rises.
- SAMPLE: `ACQ` to `ACQ` while `win_en` stays high.
- CLOSE: `ACQ` to `REPORT` when `win_en` falls.
- REOPEN: `REPORT` to `ACQ` when `win_en` is high again at once.
- RETIRE: `REPORT` to `IDLE` otherwise.

At CLOSE the result is compared with `expected` and the verdict is stored. The verdict stays valid until the next window opens.

Top module: `compact_resp_analyzer`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `result`=0, `hex_digit`=0, `done`=0 and `pass`=0. The block starts in `IDLE`.
- R2: At OPEN the previous result is discarded, and the new window's first sample is applied to a zero accumulator. The method is taken from `mode_sel` at that edge: 0 is transition count, 1 is ones count, and 2 or 3 is signature.
- R3: In transition-count mode the first sample of a window only loads the previous-bit register and does not count. Every later sample that differs from the sample before it adds one.
- R4: In ones-count mode every sample equal to 1 adds one, including the first sample of the window.
- R5: In signature mode each sample updates the register as new = {old[14:0], old[15]^old[11]^old[8]^old[6]^din}. The register starts from zero, so the first sample gives `din`.
- R6: Both counting modes hold at 16'hFFFF instead of wrapping.
- R7: When `win_en` is low at an edge, `result` does not change, whatever `din` does.
- R8: `done` is high for exactly the one cycle that follows the CLOSE edge. It never follows a cycle in which `win_en` was high.
- R9: At CLOSE, `pass` becomes 1 if the final result equals `expected` at that edge and 0 otherwise. It then holds until the next OPEN, which clears it to 0.
- R10: `hex_digit[i]` always equals `result[4*i+3:4*i]` for each of the four digits.
- R11: A change of `mode_sel` while a window is open has no effect on that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Compression method, sampled at OPEN |
| win_en | input | 1 | Measurement window, high while sampling |
| din | input | 1 | Sampled test-point bit |
| expected | input | 16 | Fault-free reference value |
| result | output | 16 | Accumulated count or signature |
| hex_digit | output | 4x4 | Result split into hexadecimal digits, digit 0 least significant |
| done | output | 1 | One-cycle pulse after a window closes |
| pass | output | 1 | Result matched the reference at the last close |

## Verification
The bench builds the analyzer with its default 16-bit width and the default tap mask. With that width, a ones-count window of about 65,540 consecutive 1s fits easily in the run and reaches the saturation point, so R6 is exercised on the real register size and not on a reduced one. The same default width means the four display digits and the signature feedback taps are checked at the size an operator would actually read.

// File: rtl/cra_pkg.sv
package cra_pkg;

    typedef enum logic [1:0] {
        MODE_TRANS = 2'd0,
        MODE_ONES  = 2'd1,
        MODE_SIG   = 2'd2
    } cra_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACQ    = 2'd1,
        ST_REPORT = 2'd2
    } cra_state_t;

    function automatic cra_mode_t decode_mode(input logic [1:0] sel);
        cra_mode_t m;
        unique case (sel)
            2'd0:    m = MODE_TRANS;
            2'd1:    m = MODE_ONES;
            default: m = MODE_SIG;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cra_ctrl.sv
module cra_ctrl
    import cra_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       win_en,
    input  logic [1:0] mode_sel,
    output logic       first_smp,
    output logic       smp,
    output logic       close,
    output logic       done,
    output cra_mode_t  mode_act
);

    cra_state_t state_q;
    cra_state_t state_d;
    cra_mode_t  mode_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_TRANS;
        end else begin
            state_q <= state_d;
            if (first_smp) begin
                mode_q <= decode_mode(mode_sel);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_en) state_d = ST_ACQ;
            ST_ACQ:    if (!win_en) state_d = ST_REPORT;
            ST_REPORT: state_d = win_en ? ST_ACQ : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        first_smp = 1'b0;
        smp       = 1'b0;
        close     = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   first_smp = win_en;
            ST_ACQ: begin
                smp   = win_en;
                close = !win_en;
            end
            ST_REPORT: begin
                done      = 1'b1;
                first_smp = win_en;
            end
            default: ;
        endcase
        mode_act = first_smp ? decode_mode(mode_sel) : mode_q;
    end

endmodule

// File: rtl/cra_compress.sv
module cra_compress
    import cra_pkg::*;
#(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'h8940
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first_smp,
    input  logic             smp,
    input  cra_mode_t        mode_act,
    input  logic             din,
    output logic [WIDTH-1:0] acc
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] TAP_MASK = WIDTH'(TAPS);

    logic             prev_q;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] acc_d;
    logic [WIDTH-1:0] inc_val;
    logic [WIDTH-1:0] sig_val;
    logic [WIDTH-1:0] base;
    logic             bump;

    // a fresh window starts from zero
    assign base    = first_smp ? '0 : acc_q;
    assign inc_val = (&base) ? ALL_ONES : base + 1'b1;
    assign sig_val = {base[WIDTH-2:0], (^(base & TAP_MASK)) ^ din};

    always_comb begin
        bump = 1'b0;
        unique case (mode_act)
            MODE_TRANS: bump = !first_smp && (din != prev_q);
            MODE_ONES:  bump = din;
            default:    bump = 1'b0;
        endcase
        if (mode_act == MODE_SIG) begin
            acc_d = sig_val;
        end else begin
            acc_d = bump ? inc_val : base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            prev_q <= 1'b0;
        end else if (first_smp || smp) begin
            acc_q  <= acc_d;
            prev_q <= din;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/cra_digits.sv
module cra_digits #(
    parameter int WIDTH = 16,
    localparam int NIB = WIDTH / 4
) (
    input  logic [WIDTH-1:0]       value,
    output logic [NIB-1:0][3:0]    digit
);

    for (genvar i = 0; i < NIB; i++) begin : g_nib
        assign digit[i] = value[4*i +: 4];
    end

endmodule

// File: rtl/cra_judge.sv
module cra_judge #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             first_smp,
    input  logic             close,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] expected,
    output logic             pass
);

    always_ff @(posedge clk) begin
        if (rst || first_smp) begin
            pass <= 1'b0;
        end else if (close) begin
            pass <= (acc == expected);
        end
    end

endmodule

// File: rtl/compact_resp_analyzer.sv
module compact_resp_analyzer
    import cra_pkg::*;
#(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'h8940,
    localparam int         NIB   = WIDTH / 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode_sel,
    input  logic                 win_en,
    input  logic                 din,
    input  logic [WIDTH-1:0]     expected,
    output logic [WIDTH-1:0]     result,
    output logic [NIB-1:0][3:0]  hex_digit,
    output logic                 done,
    output logic                 pass
);

    logic      first_smp;
    logic      smp;
    logic      close;
    cra_mode_t mode_act;

    cra_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .win_en    (win_en),
        .mode_sel  (mode_sel),
        .first_smp (first_smp),
        .smp       (smp),
        .close     (close),
        .done      (done),
        .mode_act  (mode_act)
    );

    cra_compress #(.WIDTH(WIDTH), .TAPS(TAPS)) u_comp (
        .clk       (clk),
        .rst       (rst),
        .first_smp (first_smp),
        .smp       (smp),
        .mode_act  (mode_act),
        .din       (din),
        .acc       (result)
    );

    cra_digits #(.WIDTH(WIDTH)) u_dig (
        .value (result),
        .digit (hex_digit)
    );

    cra_judge #(.WIDTH(WIDTH)) u_judge (
        .clk       (clk),
        .rst       (rst),
        .first_smp (first_smp),
        .close     (close),
        .acc       (result),
        .expected  (expected),
        .pass      (pass)
    );

endmodule

// File: rtl/cra_chk.sv
module cra_chk
    import cra_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int NIB = WIDTH / 4
) (
    input logic                clk,
    input logic                rst,
    input logic                win_en,
    input logic [WIDTH-1:0]    result,
    input logic [NIB-1:0][3:0] hex_digit,
    input logic [WIDTH-1:0]    expected,
    input logic                done,
    input logic                pass,
    input logic                smp,
    input cra_mode_t           mode_act
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !$past(win_en));

    // R7
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !win_en |=> $stable(result));

    // R9
    verdict_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (pass == ($past(expected) == result)));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (smp && mode_act != MODE_SIG && (&result)) |=> (&result));

    // R10
    digits_chk: assert property (@(posedge clk) disable iff (rst)
        hex_digit == result);

endmodule

bind compact_resp_analyzer cra_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .win_en    (win_en),
    .result    (result),
    .hex_digit (hex_digit),
    .expected  (expected),
    .done      (done),
    .pass      (pass),
    .smp       (smp),
    .mode_act  (mode_act)
);

// File: tb/compact_resp_analyzer_bench.sv
module compact_resp_analyzer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'd0;
    logic        win_en = 1'b0;
    logic        din = 1'b0;
    logic [15:0] expected = 16'h0;
    logic [15:0] result;
    logic [3:0][3:0] hex_digit;
    logic        done;
    logic        pass;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    compact_resp_analyzer u_compact_resp_analyzer (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .win_en    (win_en),
        .din       (din),
        .expected  (expected),
        .result    (result),
        .hex_digit (hex_digit),
        .done      (done),
        .pass      (pass)
    );

    always #4 clk = ~clk;

    // behavioural reference
    bit m_open = 0;
    int m_mode = 0;
    int m_acc  = 0;
    int m_prev = 0;
    bit m_done = 0;
    bit m_pass = 0;

    function automatic int sig_step(int a, int d);
        int fb;
        fb = ((a >> 15) ^ (a >> 11) ^ (a >> 8) ^ (a >> 6) ^ d) & 1;
        return ((a << 1) | fb) & 16'hFFFF;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_open = 0; m_mode = 0; m_acc = 0; m_prev = 0; m_done = 0; m_pass = 0;
        end else if (win_en) begin
            m_done = 0;
            if (!m_open) begin
                m_open = 1;
                m_mode = (mode_sel >= 2) ? 2 : int'(mode_sel);
                m_pass = 0;
                if (m_mode == 0) m_acc = 0;
                else if (m_mode == 1) m_acc = int'(din);
                else m_acc = sig_step(0, int'(din));
            end else begin
                if (m_mode == 0) begin
                    if (int'(din) != m_prev && m_acc != 16'hFFFF) m_acc++;
                end else if (m_mode == 1) begin
                    if (din && m_acc != 16'hFFFF) m_acc++;
                end else begin
                    m_acc = sig_step(m_acc, int'(din));
                end
            end
            m_prev = int'(din);
        end else begin
            if (m_open) begin
                m_open = 0;
                m_done = 1;
                m_pass = (m_acc == int'(expected));
            end else begin
                m_done = 0;
            end
        end
        #2;
        if (!finished) begin
            check("R3/R4/R5 model result", int'(result), m_acc);
            check("R8 model done", int'(done), int'(m_done));
            check("R9 model pass", int'(pass), int'(m_pass));
            check("R10 model digits", int'(hex_digit), m_acc);
        end
    end

    task automatic sample(bit d);
        @(negedge clk);
        win_en = 1'b1;
        din = d;
    endtask

    // close the window and stop just after the CLOSE edge
    task automatic close_win();
        @(negedge clk);
        win_en = 1'b0;
        @(posedge clk);
        #3;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            win_en = 1'b0;
            din = ~din;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int sig;
        bit pat [];
        repeat (3) @(negedge clk);
        @(posedge clk); #3;
        check("R1 reset result", int'(result), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset pass", int'(pass), 0);
        check("R1 reset digits", int'(hex_digit), 0);
        @(negedge clk);
        rst = 1'b0;

        // R3 transition count, first sample not counted
        mode_sel = 2'd0;
        expected = 16'd4;
        pat = '{0, 1, 1, 0, 1, 0, 0};
        foreach (pat[i]) sample(pat[i]);
        close_win();
        check("R3 transitions", int'(result), 4);
        check("R8 done after close", int'(done), 1);
        check("R9 pass on match", int'(pass), 1);
        @(posedge clk); #3;
        check("R8 done one cycle", int'(done), 0);
        check("R9 pass held", int'(pass), 1);

        // R7 data ignored while closed
        idle(6);
        @(posedge clk); #3;
        check("R7 frozen result", int'(result), 4);

        // R3 first sample of 1 alone counts nothing
        sample(1);
        close_win();
        check("R3 first sample", int'(result), 0);
        check("R9 mismatch", int'(pass), 0);

        // R4 ones count, wrong reference
        idle(2);
        mode_sel = 2'd1;
        expected = 16'd9;
        pat = '{1, 0, 1, 1, 0, 1};
        foreach (pat[i]) sample(pat[i]);
        close_win();
        check("R4 ones", int'(result), 4);
        check("R9 fail flag", int'(pass), 0);

        // R5 signature and R11 mode change mid window; R2 open discards
        idle(2);
        mode_sel = 2'd2;
        sig = 0;
        for (int i = 0; i < 40; i++) begin
            bit b;
            b = ((i * 7 + 3) % 5) < 2;
            sig = sig_step(sig, int'(b));
            sample(b);
            if (i == 0) begin
                @(posedge clk); #3;
                check("R2 open clears", int'(result), int'(b));
                check("R9 cleared at open", int'(pass), 0);
            end
            if (i == 10) mode_sel = 2'd0;
        end
        expected = 16'(sig);
        close_win();
        check("R5 signature", int'(result), sig);
        check("R11 mode held", int'(result), sig);
        check("R9 sig pass", int'(pass), 1);
        check("R10 digit3", int'(hex_digit[3]), (sig >> 12) & 15);
        check("R10 digit0", int'(hex_digit[0]), sig & 15);

        // REOPEN straight from REPORT with mode 3 as signature
        mode_sel = 2'd3;
        sample(1);
        @(posedge clk); #3;
        check("R8 reopen drops done", int'(done), 0);
        check("R2 mode3 signature", int'(result), 1);
        sample(1);
        close_win();
        check("R5 second step", int'(result), 3);

        // R1 reset mid window
        idle(1);
        mode_sel = 2'd1;
        sample(1); sample(1);
        @(negedge clk);
        rst = 1'b1; win_en = 1'b0;
        @(posedge clk); #3;
        check("R1 mid reset result", int'(result), 0);
        @(negedge clk);
        rst = 1'b0;

        // R6 saturation in ones mode
        mode_sel = 2'd1;
        expected = 16'hFFFF;
        for (int i = 0; i < 65540; i++) sample(1);
        close_win();
        check("R6 saturate", int'(result), 16'hFFFF);
        check("R9 pass at max", int'(pass), 1);

        idle(3);
        finish_run();
    end

endmodule